// File: doc/BRIEF.md
# Miss Holding Register File with Target Merging

This block tracks outstanding cache misses. It has a fixed number of entries. Each entry holds a block address, an address-space identifier, the requesting thread, the command to send downstream, an in-service flag and an ordered list of waiting requesters (targets). An incoming miss is compared against every live entry. If an entry already covers the same block in the same address space, the miss joins that entry as one more target. Otherwise the miss claims a free entry.

Pending entries are offered one at a time on an issue stream. When the downstream side accepts an entry, that entry is marked in service. A response naming an in-service entry starts a drain: every target of that entry is presented on a target stream, one per accepted transfer, in list order. The entry is freed after its last target. A squash input frees every entry that belongs to one thread. Plain status pins report a full file, a merge blocked by a full target list, and whether a bus request is needed.

Merging has three side effects. A target from a different thread marks the entry as shared. A write merged before issue turns the outgoing command into a write. An invalidate merged into an issued read entry is placed ahead of the first non-read target.

Top module: `mshr_file`

## Requirements
- R1: A miss whose block address and address-space identifier both equal those of a live (not draining) entry is a hit. It appends to that entry's targets, and `req_hit` is high with `req_idx` naming that entry. A miss that differs in either field does not merge.
- R2: A miss that is not a hit takes the lowest-index free entry, and `req_idx` reports that index.
- R3: A merged target whose thread differs from the entry's thread marks the entry shared (`iss_shared`=1). A squash of any thread does not free a shared entry.
- R4: Command codes are 0 read, 1 write, 2 invalidate, 3 prefetch. A write (1) merged into an entry that is not in service changes the entry's outgoing command to write. A write merged after issue leaves the command unchanged.
- R5: An invalidate (2) merged into an in-service entry whose command is read is inserted before the first target whose command is not read or prefetch. All other merges append at the tail.
- R6: `no_mshr_blk` is high exactly when every entry is valid. While it is high, a non-hit miss sees `req_ready`=0. It goes low in the cycle after an entry is freed.
- R7: A hit on an entry holding the maximum number of targets raises `no_tgt_blk` and drops `req_ready`, and the request is not taken.
- R8: `bus_req` is high while any pending (not in service) entry has a command other than prefetch (3). A prefetch entry alone shows `iss_valid`=1 with `bus_req`=0. `bus_req` is low when nothing is pending.
- R9: After an accepted response for an in-service entry, `tgt_valid` stays high and presents that entry's targets in list order, advancing only on `tgt_ready`. The fields hold steady while `tgt_ready` is low. The entry is freed after the last target.
- R10: A squash frees, in one cycle, every valid non-shared entry of the given thread, except an entry that is draining.
- R11: The issue stream presents the lowest-index pending entry. An accepted transfer marks that entry in service, and the stream moves to the next pending entry.
- R12: After reset no entry is valid. `iss_valid`, `tgt_valid`, `bus_req`, `no_mshr_blk` and `no_tgt_blk` are low, and `req_ready` and `rsp_ready` are high.

Stream rules: a transfer happens on a clock edge where valid and ready are both high. `req_ready` is low during a squash. `rsp_ready` is low while a drain is active or a squash is present. A response naming an entry that is not in service is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Miss request can be taken |
| req_addr | input | ADDR_W | Block address of the miss |
| req_asid | input | ASID_W | Address-space identifier |
| req_thread | input | THR_W | Requesting thread |
| req_cmd | input | 2 | Command (0 rd, 1 wr, 2 inv, 3 pf) |
| req_tag | input | TAG_W | Requester tag stored as target |
| req_hit | output | 1 | Request matches a live entry |
| req_idx | output | IDX_W | Entry that takes the request |
| iss_valid | output | 1 | A pending entry is offered |
| iss_ready | input | 1 | Downstream takes the offered entry |
| iss_idx | output | IDX_W | Offered entry index |
| iss_addr | output | ADDR_W | Offered block address |
| iss_asid | output | ASID_W | Offered address-space identifier |
| iss_cmd | output | 2 | Offered outgoing command |
| iss_shared | output | 1 | Offered entry has targets from several threads |
| rsp_valid | input | 1 | Response arrives |
| rsp_ready | output | 1 | Response can be taken |
| rsp_idx | input | IDX_W | Entry the response belongs to |
| tgt_valid | output | 1 | A drained target is presented |
| tgt_ready | input | 1 | Consumer takes the target |
| tgt_tag | output | TAG_W | Target tag |
| tgt_cmd | output | 2 | Target command |
| tgt_thread | output | THR_W | Target thread |
| tgt_idx | output | IDX_W | Entry being drained |
| sq_valid | input | 1 | Squash a thread |
| sq_thread | input | THR_W | Thread to squash |
| no_mshr_blk | output | 1 | All entries in use |
| no_tgt_blk | output | 1 | Hit on an entry whose target list is full |
| bus_req | output | 1 | A non-prefetch entry awaits issue |

## Verification
The bench uses the defaults: four entries and three targets per entry. With these, the file can be filled in four misses and a target list in three, so both blocking conditions are reached after a handful of requests. Three targets are enough to place an invalidate between a leading read and a trailing write, and to observe the reordered drain order. Two threads across four entries let one bench show a squash freeing several entries while sparing a shared one.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    MC_READ  = 2'd0,
    MC_WRITE = 2'd1,
    MC_INVAL = 2'd2,
    MC_PREF  = 2'd3
  } mcmd_e;
endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int ASID_W  = 4,
  parameter int IDX_W   = 2
) (
  input  logic [ENTRIES-1:0]             live,
  input  logic [ENTRIES-1:0]             used,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
  input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  input  logic [ADDR_W-1:0]              key_addr,
  input  logic [ASID_W-1:0]              key_asid,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx,
  output logic                           has_free,
  output logic [IDX_W-1:0]               free_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = live[e] && (ent_addr[e] == key_addr) && (ent_asid[e] == key_asid);
  end

  // lowest index wins for both searches
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (eq[e]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(e);
      end
      if (!used[e]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/mshr_tlist.sv
module mshr_tlist #(
  parameter int DEPTH = 3,
  parameter int DW    = 10,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic             push,
  input  logic             reorder,
  input  logic             pop,
  input  logic [DW-1:0]    in_d,
  input  logic             in_rd,
  output logic [DW-1:0]    head_d,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  logic [DEPTH-1:0][DW-1:0] slot_d;
  logic [DEPTH-1:0]         slot_rd;
  logic [CNT_W-1:0]         lead;
  logic [CNT_W-1:0]         ins_pos;
  logic                     found;

  // first non-read slot, or the tail when all stored targets are reads
  always_comb begin
    lead  = cnt;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (CNT_W'(i) < cnt) && !slot_rd[i]) begin
        lead  = CNT_W'(i);
        found = 1'b1;
      end
    end
    ins_pos = reorder ? lead : cnt;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DW-1:0] d_q, below_d, above_d;
    logic          r_q, below_rd, above_rd;
    if (i == 0) begin : g_lo
      assign below_d  = '0;
      assign below_rd = 1'b0;
    end else begin : g_lo
      assign below_d  = slot_d[i-1];
      assign below_rd = slot_rd[i-1];
    end
    if (i == DEPTH - 1) begin : g_hi
      assign above_d  = '0;
      assign above_rd = 1'b0;
    end else begin : g_hi
      assign above_d  = slot_d[i+1];
      assign above_rd = slot_rd[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        r_q <= 1'b0;
      end else if (ld) begin
        if (i == 0) begin
          d_q <= in_d;
          r_q <= in_rd;
        end
      end else if (pop) begin
        d_q <= above_d;
        r_q <= above_rd;
      end else if (push) begin
        if (CNT_W'(i) == ins_pos) begin
          d_q <= in_d;
          r_q <= in_rd;
        end else if (CNT_W'(i) > ins_pos) begin
          d_q <= below_d;
          r_q <= below_rd;
        end
      end
    end
    assign slot_d[i]  = d_q;
    assign slot_rd[i] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (ld)   cnt <= CNT_W'(1);
    else if (pop)  cnt <= cnt - CNT_W'(1);
    else if (push) cnt <= cnt + CNT_W'(1);
  end

  assign head_d = slot_d[0];
  assign full   = (cnt == CNT_W'(DEPTH));

  assert_push_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CNT_W'(DEPTH)));
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TARGETS = 3,
  parameter int ADDR_W  = 16,
  parameter int ASID_W  = 4,
  parameter int THR_W   = 2,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [THR_W-1:0]  req_thread,
  input  logic [1:0]        req_cmd,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_hit,
  output logic [IDX_W-1:0]  req_idx,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [IDX_W-1:0]  iss_idx,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [ASID_W-1:0] iss_asid,
  output logic [1:0]        iss_cmd,
  output logic              iss_shared,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [IDX_W-1:0]  rsp_idx,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [TAG_W-1:0]  tgt_tag,
  output logic [1:0]        tgt_cmd,
  output logic [THR_W-1:0]  tgt_thread,
  output logic [IDX_W-1:0]  tgt_idx,
  input  logic              sq_valid,
  input  logic [THR_W-1:0]  sq_thread,
  output logic              no_mshr_blk,
  output logic              no_tgt_blk,
  output logic              bus_req
);
  localparam int CNT_W = $clog2(TARGETS + 1);
  localparam int TGT_W = TAG_W + THR_W + 2;

  logic [ENTRIES-1:0]             ent_v, ent_busy, ent_shr;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][THR_W-1:0]  ent_thr;
  logic [ENTRIES-1:0][1:0]        ent_cmd;
  logic                           drain_act;
  logic [IDX_W-1:0]               drain_idx;

  logic [ENTRIES-1:0]             dr_vec, pend, eff_busy, sq_hit, free_vec, bus_vec;
  logic [ENTRIES-1:0][CNT_W-1:0]  tl_cnt;
  logic [ENTRIES-1:0][TGT_W-1:0]  tl_head;
  logic [ENTRIES-1:0]             tl_full;
  logic                           hit, has_free;
  logic [IDX_W-1:0]               hit_idx, free_idx;
  logic                           req_fire, alloc_fire, merge_fire;
  logic                           iss_fire, rsp_fire, tgt_fire, last_pop;
  logic [TGT_W-1:0]               new_tgt, head;
  logic                           new_rd;

  mshr_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_lookup (
    .live(ent_v & ~dr_vec), .used(ent_v), .ent_addr(ent_addr), .ent_asid(ent_asid),
    .key_addr(req_addr), .key_asid(req_asid),
    .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
  );

  // request side
  assign req_ready  = !sq_valid && (hit ? !tl_full[hit_idx] : has_free);
  assign req_fire   = req_valid && req_ready;
  assign alloc_fire = req_fire && !hit;
  assign merge_fire = req_fire && hit;
  assign req_hit    = hit;
  assign req_idx    = hit ? hit_idx : free_idx;
  assign no_tgt_blk = req_valid && hit && tl_full[hit_idx];
  assign new_tgt    = {req_tag, req_thread, req_cmd};
  assign new_rd     = (req_cmd == MC_READ) || (req_cmd == MC_PREF);

  // issue side: lowest pending entry
  assign pend = ent_v & ~ent_busy;
  always_comb begin
    iss_valid = 1'b0;
    iss_idx   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (pend[e]) begin
        iss_valid = 1'b1;
        iss_idx   = IDX_W'(e);
      end
    end
  end
  assign iss_addr   = ent_addr[iss_idx];
  assign iss_asid   = ent_asid[iss_idx];
  assign iss_cmd    = ent_cmd[iss_idx];
  assign iss_shared = ent_shr[iss_idx];
  assign iss_fire   = iss_valid && iss_ready;

  // response and drain
  assign rsp_ready  = !drain_act && !sq_valid;
  assign rsp_fire   = rsp_valid && rsp_ready && ent_v[rsp_idx] && ent_busy[rsp_idx];
  assign head       = tl_head[drain_idx];
  assign tgt_valid  = drain_act;
  assign tgt_cmd    = head[1:0];
  assign tgt_thread = head[THR_W+1:2];
  assign tgt_tag    = head[TGT_W-1:THR_W+2];
  assign tgt_idx    = drain_idx;
  assign tgt_fire   = tgt_valid && tgt_ready;
  assign last_pop   = tgt_fire && (tl_cnt[drain_idx] == CNT_W'(1));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic ld, push, reorder, pop;
    assign dr_vec[e]   = drain_act && (drain_idx == IDX_W'(e));
    assign eff_busy[e] = ent_busy[e] || (iss_fire && iss_idx == IDX_W'(e));
    assign sq_hit[e]   = sq_valid && ent_v[e] && !ent_shr[e] && (ent_thr[e] == sq_thread) && !dr_vec[e];
    assign free_vec[e] = sq_hit[e] || (last_pop && dr_vec[e]);
    assign bus_vec[e]  = pend[e] && (ent_cmd[e] != MC_PREF);
    assign ld          = alloc_fire && (free_idx == IDX_W'(e));
    assign push        = merge_fire && (hit_idx == IDX_W'(e));
    assign reorder     = push && (req_cmd == MC_INVAL) && eff_busy[e] && (ent_cmd[e] == MC_READ);
    assign pop         = tgt_fire && dr_vec[e];

    mshr_tlist #(.DEPTH(TARGETS), .DW(TGT_W), .CNT_W(CNT_W)) u_tlist (
      .clk(clk), .rst_n(rst_n), .clr(free_vec[e]), .ld(ld), .push(push),
      .reorder(reorder), .pop(pop), .in_d(new_tgt), .in_rd(new_rd),
      .head_d(tl_head[e]), .cnt(tl_cnt[e]), .full(tl_full[e])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v[e]    <= 1'b0;
        ent_busy[e] <= 1'b0;
        ent_shr[e]  <= 1'b0;
        ent_addr[e] <= '0;
        ent_asid[e] <= '0;
        ent_thr[e]  <= '0;
        ent_cmd[e]  <= MC_READ;
      end else if (free_vec[e]) begin
        ent_v[e]    <= 1'b0;
        ent_busy[e] <= 1'b0;
        ent_shr[e]  <= 1'b0;
      end else if (ld) begin
        ent_v[e]    <= 1'b1;
        ent_busy[e] <= 1'b0;
        ent_shr[e]  <= 1'b0;
        ent_addr[e] <= req_addr;
        ent_asid[e] <= req_asid;
        ent_thr[e]  <= req_thread;
        ent_cmd[e]  <= req_cmd;
      end else begin
        if (iss_fire && iss_idx == IDX_W'(e)) ent_busy[e] <= 1'b1;
        if (push) begin
          if (req_thread != ent_thr[e]) ent_shr[e] <= 1'b1;
          if (!eff_busy[e] && req_cmd == MC_WRITE) ent_cmd[e] <= MC_WRITE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drain_act <= 1'b0;
      drain_idx <= '0;
    end else if (rsp_fire) begin
      drain_act <= 1'b1;
      drain_idx <= rsp_idx;
    end else if (last_pop) begin
      drain_act <= 1'b0;
    end
  end

  assign no_mshr_blk = &ent_v;
  assign bus_req     = |bus_vec;

  assert_full_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_mshr_blk) |-> $past(alloc_fire));
  assert_full_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_mshr_blk) |-> $past(|free_vec));
  assert_tgt_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    no_tgt_blk |-> !req_ready);
  assert_bus_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> iss_valid);
  assert_drain_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_tag) && $stable(tgt_idx)));
endmodule

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, iss_ready = 0, rsp_valid = 0, tgt_ready = 0, sq_valid = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_asid = '0;
  logic [1:0]  req_thread = '0, req_cmd = '0, rsp_idx = '0, sq_thread = '0;
  logic [5:0]  req_tag = '0;
  logic        req_ready, req_hit, iss_valid, iss_shared, rsp_ready, tgt_valid;
  logic        no_mshr_blk, no_tgt_blk, bus_req;
  logic [1:0]  req_idx, iss_idx, iss_cmd, tgt_cmd, tgt_thread, tgt_idx;
  logic [15:0] iss_addr;
  logic [3:0]  iss_asid;
  logic [5:0]  tgt_tag;
  int n_chk = 0, n_bad = 0;
  logic rdy, hit, ntb;
  logic [1:0] idx;

  always #10 clk = ~clk;

  mshr_file u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_asid(req_asid), .req_thread(req_thread), .req_cmd(req_cmd),
    .req_tag(req_tag), .req_hit(req_hit), .req_idx(req_idx), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .iss_idx(iss_idx), .iss_addr(iss_addr), .iss_asid(iss_asid),
    .iss_cmd(iss_cmd), .iss_shared(iss_shared), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_idx(rsp_idx), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_tag(tgt_tag),
    .tgt_cmd(tgt_cmd), .tgt_thread(tgt_thread), .tgt_idx(tgt_idx), .sq_valid(sq_valid),
    .sq_thread(sq_thread), .no_mshr_blk(no_mshr_blk), .no_tgt_blk(no_tgt_blk), .bus_req(bus_req)
  );

  typedef struct packed {
    logic [15:0] a; logic [3:0] s; logic [1:0] t; logic [1:0] c; logic [5:0] g;
    logic h; logic r; logic [1:0] i;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{16'h0010, 4'd1, 2'd0, 2'd0, 6'd1, 1'b0, 1'b1, 2'd0},
    '{16'h0020, 4'd1, 2'd1, 2'd0, 6'd2, 1'b0, 1'b1, 2'd1},
    '{16'h0010, 4'd2, 2'd0, 2'd0, 6'd3, 1'b0, 1'b1, 2'd2},
    '{16'h0010, 4'd1, 2'd0, 2'd0, 6'd4, 1'b1, 1'b1, 2'd0},
    '{16'h0010, 4'd1, 2'd0, 2'd1, 6'd5, 1'b1, 1'b1, 2'd0},
    '{16'h0010, 4'd1, 2'd0, 2'd0, 6'd6, 1'b1, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {req_valid, iss_ready, rsp_valid, tgt_ready, sq_valid} = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_req(input logic [15:0] a, input logic [3:0] s, input logic [1:0] t,
                        input logic [1:0] c, input logic [5:0] g);
    @(negedge clk);
    req_addr = a; req_asid = s; req_thread = t; req_cmd = c; req_tag = g; req_valid = 1'b1;
    #1;
    rdy = req_ready; hit = req_hit; idx = req_idx; ntb = no_tgt_blk;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_issue();
    @(negedge clk);
    iss_ready = 1'b1;
    @(posedge clk);
    #1 iss_ready = 1'b0;
  endtask

  task automatic do_rsp(input logic [1:0] i);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_idx = i;
    @(posedge clk);
    #1 rsp_valid = 1'b0;
  endtask

  task automatic do_sq(input logic [1:0] t);
    @(negedge clk);
    sq_valid = 1'b1; sq_thread = t;
    @(posedge clk);
    #1 sq_valid = 1'b0;
  endtask

  task automatic take_tgt(input string tag, input logic [5:0] g, input logic [1:0] c);
    @(negedge clk);
    chk({tag, " tgt_valid"}, 32'(tgt_valid), 32'd1);
    chk({tag, " tgt_tag"}, 32'(tgt_tag), 32'(g));
    chk({tag, " tgt_cmd"}, 32'(tgt_cmd), 32'(c));
    tgt_ready = 1'b1;
    @(posedge clk);
    #1 tgt_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R12 reset state
    @(negedge clk);
    chk("R12 iss_valid", 32'(iss_valid), 0);
    chk("R12 tgt_valid", 32'(tgt_valid), 0);
    chk("R12 bus_req", 32'(bus_req), 0);
    chk("R12 no_mshr_blk", 32'(no_mshr_blk), 0);
    chk("R12 no_tgt_blk", 32'(no_tgt_blk), 0);
    chk("R12 req_ready", 32'(req_ready), 1);
    chk("R12 rsp_ready", 32'(rsp_ready), 1);

    // table: R1 match on addr+asid, R2 allocation order, R7 full target list
    for (int k = 0; k < 6; k++) begin
      do_req(VECS[k].a, VECS[k].s, VECS[k].t, VECS[k].c, VECS[k].g);
      chk($sformatf("R1 vec%0d req_hit", k), 32'(hit), 32'(VECS[k].h));
      chk($sformatf("R7 vec%0d req_ready", k), 32'(rdy), 32'(VECS[k].r));
      chk($sformatf("R2 vec%0d req_idx", k), 32'(idx), 32'(VECS[k].i));
      if (k == 5) chk("R7 no_tgt_blk", 32'(ntb), 1);
    end
    @(negedge clk);
    chk("R11 iss_idx", 32'(iss_idx), 0);
    chk("R4 write upgrade", 32'(iss_cmd), 1);
    chk("R8 bus_req demand", 32'(bus_req), 1);
    do_issue();
    @(negedge clk);
    chk("R11 next pending", 32'(iss_idx), 1);
    do_rsp(2'd0);
    // R9 hold under back-pressure
    @(negedge clk);
    chk("R9 hold tag", 32'(tgt_tag), 1);
    @(negedge clk);
    chk("R9 still held", 32'(tgt_tag), 1);
    chk("R9 tgt_idx", 32'(tgt_idx), 0);
    take_tgt("R9 t0", 6'd1, 2'd0);
    take_tgt("R9 t1", 6'd4, 2'd0);
    take_tgt("R9 t2", 6'd5, 2'd1);
    @(negedge clk);
    chk("R9 drain done", 32'(tgt_valid), 0);
    do_req(16'h0030, 4'd1, 2'd0, 2'd0, 6'd7);
    chk("R2 reuse lowest", 32'(idx), 0);
    chk("R2 not hit", 32'(hit), 0);

    // R6 full file and R10 multi-entry squash
    do_reset();
    do_req(16'h0100, 4'd0, 2'd0, 2'd0, 6'd1);
    do_req(16'h0200, 4'd0, 2'd0, 2'd0, 6'd2);
    do_req(16'h0300, 4'd0, 2'd0, 2'd0, 6'd3);
    do_req(16'h0400, 4'd0, 2'd1, 2'd0, 6'd4);
    @(negedge clk);
    chk("R6 full", 32'(no_mshr_blk), 1);
    do_req(16'h0500, 4'd0, 2'd1, 2'd0, 6'd5);
    chk("R6 miss stalled", 32'(rdy), 0);
    do_sq(2'd1);
    @(negedge clk);
    chk("R6 full cleared", 32'(no_mshr_blk), 0);
    do_req(16'h0500, 4'd0, 2'd1, 2'd0, 6'd5);
    chk("R2 freed slot", 32'(idx), 3);
    do_sq(2'd0);
    @(negedge clk);
    chk("R10 survivor idx", 32'(iss_idx), 3);
    do_issue();
    @(negedge clk);
    chk("R10 all thread0 freed", 32'(iss_valid), 0);

    // R3 shared entry survives squash
    do_reset();
    do_req(16'h0A00, 4'd0, 2'd0, 2'd0, 6'd1);
    do_req(16'h0B00, 4'd0, 2'd0, 2'd0, 6'd2);
    do_req(16'h0C00, 4'd0, 2'd1, 2'd0, 6'd3);
    do_req(16'h0B00, 4'd0, 2'd1, 2'd0, 6'd4);
    chk("R3 merge hit", 32'(hit), 1);
    do_sq(2'd0);
    @(negedge clk);
    chk("R3 shared kept", 32'(iss_idx), 1);
    chk("R3 iss_shared", 32'(iss_shared), 1);
    do_sq(2'd1);
    do_issue();
    @(negedge clk);
    chk("R10 thread1 entry freed", 32'(iss_valid), 0);

    // R8 prefetch does not request the bus
    do_reset();
    do_req(16'h0D00, 4'd0, 2'd0, 2'd3, 6'd1);
    @(negedge clk);
    chk("R8 pf pending", 32'(iss_valid), 1);
    chk("R8 pf no bus", 32'(bus_req), 0);
    do_req(16'h0E00, 4'd0, 2'd0, 2'd0, 6'd2);
    @(negedge clk);
    chk("R8 demand bus", 32'(bus_req), 1);
    do_issue();
    do_issue();
    @(negedge clk);
    chk("R8 bus cleared", 32'(bus_req), 0);
    chk("R11 none pending", 32'(iss_valid), 0);

    // R5 invalidate reordered, R4 no upgrade after issue
    do_reset();
    do_req(16'h0F00, 4'd0, 2'd0, 2'd0, 6'd1);
    do_issue();
    do_req(16'h0F00, 4'd0, 2'd0, 2'd1, 6'd2);
    do_req(16'h0F00, 4'd0, 2'd0, 2'd2, 6'd3);
    chk("R5 inval merged", 32'(hit), 1);
    do_rsp(2'd0);
    take_tgt("R5 first read", 6'd1, 2'd0);
    take_tgt("R5 inval moved", 6'd3, 2'd2);
    take_tgt("R5 write last", 6'd2, 2'd1);
    @(negedge clk);
    chk("R9 entry freed", 32'(tgt_valid), 0);
    do_req(16'h0F00, 4'd0, 2'd0, 2'd0, 6'd4);
    chk("R4 freed entry no hit", 32'(hit), 0);
    @(negedge clk);
    chk("R4 fresh cmd read", 32'(iss_cmd), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule